// File: doc/BRIEF.md
# Cascaded Encoded Interrupt Status Controller

This block gathers interrupt requests from three tiers of sources (critical, main and peripheral), filters them through software-written mask registers and presents the result as one read-only encoded status word. Each tier has its own valid flag and index field in that word. Two fixed slots, one in the critical tier and one in the main tier, do not come from external lines. They stand for pending peripheral work: urgent peripheral work in the critical tier, ordinary peripheral work in the main tier. When one of them wins, the peripheral field names the real source. Peripheral slot 0 is itself a cascade. It is fed by a 17-bit secondary pending register that has its own mask and write-one-to-clear behaviour.

Software programs the masks and clears secondary pending bits through a small register port. It reads the status word to find the source, and it can also take the fully resolved flat source number from `src_id`. The CPU interrupt line is the OR of the three tier valid flags. A parameter chooses which peripheral sources count as urgent.

Top module: `irq_status_encoder`

## Requirements
- R1: After reset every used mask bit reads one (main mask 0x0001FFFF at address 0, peripheral mask 0xFFFFFE00 at address 1, secondary mask 0x0001FFFF at address 2), the secondary pending register (address 3) reads zero, and all sources are disabled.
- R2: The critical field holds its valid flag in status bit 10 and its 2-bit index in bits 9:8. The critical sources are 0, 1 and 3 from `crit_ext[0]`, `crit_ext[1]` and `crit_ext[2]`, with no mask. Slot 2 is active when any enabled urgent peripheral source is pending. The lowest active slot wins.
- R3: The main field holds its valid flag in bit 21 and its 5-bit index in bits 20:16. Main source k is disabled by main mask bit (16-k). Sources 0-3 come from `main_ext[3:0]` and sources 5-16 from `main_ext[15:4]`. Slot 4 is active when any enabled non-urgent peripheral source is pending. The lowest enabled active slot wins.
- R4: The peripheral field holds its valid flag in bit 29 and its 5-bit index in bits 28:24. Peripheral source k is disabled by peripheral mask bit (31-k), and sources 1-22 come from `per_ext[21:0]`. The field names the lowest active urgent source if there is one, and otherwise the lowest active non-urgent source.
- R5: A pulse on `sec_evt[k]` sets secondary pending bit k. Writing a one to bit k at address 3 clears it, and writing zero leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R6: Peripheral source 0 is active when any secondary pending bit is set whose secondary mask bit k is zero. The mask does not stop the bit from being recorded.
- R7: `src_id` is 0 when nothing is valid. Otherwise the critical tier is resolved first, then main, then peripheral. Critical index i (i not 2) gives 1+i, and main index i (i not 4) gives 5+i. Escape slots pass resolution to the peripheral field. Peripheral index p (p not 0) gives 39+p, and peripheral index 0 gives 22 plus the lowest enabled secondary pending bit.
- R8: `irq_out` is the OR of status bits 10, 21 and 29.
- R9: Status bits outside the three fields read zero. Register reads return zero in the bits that no register uses.
- R10: The status word, `src_id` and `irq_out` follow the request inputs in the same cycle. Register writes and `sec_evt` take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_ext | input | 3 | Critical sources 0, 1, 3 (level) |
| main_ext | input | 16 | Main sources 0-3, 5-16 (level) |
| per_ext | input | 22 | Peripheral sources 1-22 (level) |
| sec_evt | input | 17 | Set pulses for the secondary pending register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 main mask, 1 peripheral mask, 2 secondary mask, 3 secondary pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| stat_word | output | 32 | Encoded status word |
| src_id | output | 6 | Resolved flat source number, 0 when idle |
| irq_out | output | 1 | Interrupt to the CPU |

## Verification
The status word, `src_id`, `irq_out` and `reg_rdata` are combinational, so they are due in the cycle the inputs change. Register writes and secondary set pulses become visible one edge later. The bench drives every input on the falling edge and compares all outputs against its model one time unit later. It updates that model only after the following rising edge, so a write is first checked in the cycle after it is issued. Random traffic is mixed with directed cases: escape slots, the secondary cascade, and a set and clear in the same cycle.

// File: rtl/irq_status_encoder.sv
module irq_status_encoder #(
  parameter logic [22:0] URGENT_SET = 23'h000060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  crit_ext,
  input  logic [15:0] main_ext,
  input  logic [21:0] per_ext,
  input  logic [16:0] sec_evt,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] stat_word,
  output logic [5:0]  src_id,
  output logic        irq_out
);
  localparam int NMAIN = 17;
  localparam int NPER  = 23;
  localparam int NSEC  = 17;
  localparam int MAIN_ESC = 4;
  localparam int CRIT_ESC = 2;

  function automatic logic [4:0] low_idx(input logic [22:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 22; i >= 0; i--)
      if (v[i]) r = 5'(i);
    return r;
  endfunction

  logic [NMAIN-1:0] main_mask_q;
  logic [NPER-1:0]  per_mask_q;
  logic [NSEC-1:0]  sec_mask_q;
  logic [NSEC-1:0]  sec_pend_q;
  logic [NSEC-1:0]  sec_clr;

  assign sec_clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata[NSEC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_mask_q <= '1;
      per_mask_q  <= '1;
      sec_mask_q  <= '1;
      sec_pend_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) main_mask_q <= reg_wdata[NMAIN-1:0];
      if (reg_wr && reg_addr == 2'd1) per_mask_q  <= reg_wdata[31:32-NPER];
      if (reg_wr && reg_addr == 2'd2) sec_mask_q  <= reg_wdata[NSEC-1:0];
      sec_pend_q <= (sec_pend_q & ~sec_clr) | sec_evt;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {15'd0, main_mask_q};
      2'd1:    reg_rdata = {per_mask_q, 9'd0};
      2'd2:    reg_rdata = {15'd0, sec_mask_q};
      default: reg_rdata = {15'd0, sec_pend_q};
    endcase
  end

  logic [NSEC-1:0]  sec_act;
  logic [NPER-1:0]  per_act, urg_act, nrm_act, per_pick;
  logic [NMAIN-1:0] main_act;
  logic [3:0]       crit_act;

  assign sec_act    = sec_pend_q & ~sec_mask_q;
  assign per_act[0] = ~per_mask_q[NPER-1] & (|sec_act);

  genvar k;
  generate
    for (k = 1; k < NPER; k++) begin : g_per
      assign per_act[k] = ~per_mask_q[NPER-1-k] & per_ext[k-1];
    end
  endgenerate

  assign urg_act  = per_act & URGENT_SET;
  assign nrm_act  = per_act & ~URGENT_SET;
  assign per_pick = (|urg_act) ? urg_act : nrm_act;

  assign crit_act = {crit_ext[2], |urg_act, crit_ext[1:0]};

  generate
    for (k = 0; k < NMAIN; k++) begin : g_main
      if (k == MAIN_ESC) begin : g_esc
        assign main_act[k] = ~main_mask_q[NMAIN-1-k] & (|nrm_act);
      end else if (k < MAIN_ESC) begin : g_lo
        assign main_act[k] = ~main_mask_q[NMAIN-1-k] & main_ext[k];
      end else begin : g_hi
        assign main_act[k] = ~main_mask_q[NMAIN-1-k] & main_ext[k-1];
      end
    end
  endgenerate

  logic       crit_v, main_v, per_v;
  logic [1:0] crit_i;
  logic [4:0] main_i, per_i, sec_i, t_crit, t_main;

  assign crit_v = |crit_act;
  assign main_v = |main_act;
  assign per_v  = |per_act;
  assign t_crit = low_idx({19'd0, crit_act});
  assign t_main = low_idx({6'd0, main_act});
  assign crit_i = t_crit[1:0];
  assign main_i = t_main;
  assign per_i  = low_idx(per_pick);
  assign sec_i  = low_idx({6'd0, sec_act});

  always_comb begin
    stat_word        = '0;
    stat_word[10]    = crit_v;
    stat_word[9:8]   = crit_i;
    stat_word[21]    = main_v;
    stat_word[20:16] = main_i;
    stat_word[29]    = per_v;
    stat_word[28:24] = per_i;
  end

  logic [5:0] per_id;
  assign per_id = (per_i == 5'd0) ? 6'd22 + {1'b0, sec_i} : 6'd39 + {1'b0, per_i};

  always_comb begin
    if (crit_v && crit_i != 2'(CRIT_ESC))      src_id = 6'd1 + {4'd0, crit_i};
    else if (crit_v)                           src_id = per_id;
    else if (main_v && main_i != 5'(MAIN_ESC)) src_id = 6'd5 + {1'b0, main_i};
    else if (main_v || per_v)                  src_id = per_id;
    else                                       src_id = 6'd0;
  end

  assign irq_out = crit_v | main_v | per_v;
endmodule

module irq_status_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [16:0] sec_evt,
  input logic [16:0] sec_pend_q,
  input logic [31:0] stat_word,
  input logic [5:0]  src_id,
  input logic        irq_out
);
  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (stat_word[10] | stat_word[21] | stat_word[29]));
  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word & 32'hC0C0F8FF) == 32'd0);
  // R7
  id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> src_id == 6'd0);
  // R7
  id_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> src_id != 6'd0);
  // R2
  crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[10] && stat_word[9:8] != 2'd2) |-> src_id == 6'd1 + {4'd0, stat_word[9:8]});
  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt == 17'd0 && !(reg_wr && reg_addr == 2'd3)) |=> $stable(sec_pend_q));
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3 && sec_evt == 17'd0) |=> (sec_pend_q & $past(reg_wdata[16:0])) == 17'd0);
  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt != 17'd0) |=> (sec_pend_q & $past(sec_evt)) == $past(sec_evt));
endmodule

bind irq_status_encoder irq_status_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sec_evt(sec_evt), .sec_pend_q(sec_pend_q),
  .stat_word(stat_word), .src_id(src_id), .irq_out(irq_out)
);

// File: tb/irq_status_encoder_tb.sv
module irq_status_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] URG = 23'h000060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  crit_ext = '0;
  logic [15:0] main_ext = '0;
  logic [21:0] per_ext = '0;
  logic [16:0] sec_evt = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, stat_word;
  logic [5:0]  src_id;
  logic        irq_out;

  int n_run = 0, n_fail = 0;

  logic [16:0] m_main, m_smask, m_spend;
  logic [31:0] m_per;
  logic [31:0] e_stat, e_rd;
  logic [5:0]  e_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_encoder #(.URGENT_SET(URG)) dut_i (
    .clk(clk), .rst_n(rst_n), .crit_ext(crit_ext), .main_ext(main_ext),
    .per_ext(per_ext), .sec_evt(sec_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_word(stat_word),
    .src_id(src_id), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic model_eval();
    logic [22:0] pa;
    logic [16:0] ma, sa;
    logic [3:0]  ca;
    logic any_u, any_n, cv, mv, pv, f;
    int ci, mi, pi, si;
    sa = m_spend & ~m_smask;
    pa[0] = !m_per[31] && (sa != 0);
    for (int k = 1; k < 23; k++) pa[k] = !m_per[31-k] && per_ext[k-1];
    any_u = (pa & URG) != 0;
    any_n = (pa & ~URG) != 0;
    ca = {crit_ext[2], any_u, crit_ext[1:0]};
    for (int k = 0; k < 17; k++)
      ma[k] = !m_main[16-k] && (k == 4 ? any_n : (k < 4 ? main_ext[k] : main_ext[k-1]));
    cv = ca != 0; mv = ma != 0; pv = pa != 0;
    ci = 0; f = 0; for (int k = 0; k < 4; k++) if (ca[k] && !f) begin ci = k; f = 1; end
    mi = 0; f = 0; for (int k = 0; k < 17; k++) if (ma[k] && !f) begin mi = k; f = 1; end
    pi = 0; f = 0;
    for (int k = 0; k < 23; k++) if (pa[k] && URG[k] && !f) begin pi = k; f = 1; end
    for (int k = 0; k < 23; k++) if (pa[k] && !URG[k] && !f) begin pi = k; f = 1; end
    si = 0; f = 0; for (int k = 0; k < 17; k++) if (sa[k] && !f) begin si = k; f = 1; end
    e_stat = 0;
    e_stat[10] = cv; e_stat[9:8] = 2'(ci);
    e_stat[21] = mv; e_stat[20:16] = 5'(mi);
    e_stat[29] = pv; e_stat[28:24] = 5'(pi);
    if (cv && ci != 2)      e_id = 6'(1 + ci);
    else if (cv)            e_id = (pi == 0) ? 6'(22 + si) : 6'(39 + pi);
    else if (mv && mi != 4) e_id = 6'(5 + mi);
    else if (mv || pv)      e_id = (pi == 0) ? 6'(22 + si) : 6'(39 + pi);
    else                    e_id = 0;
    case (reg_addr)
      2'd0: e_rd = {15'd0, m_main};
      2'd1: e_rd = m_per;
      2'd2: e_rd = {15'd0, m_smask};
      default: e_rd = {15'd0, m_spend};
    endcase
  endtask

  // R10: inputs change on the falling edge, outputs are sampled 1 time unit later,
  // and the model takes register effects only after the following rising edge.
  task automatic step(input logic [2:0] ce, input logic [15:0] me, input logic [21:0] pe,
                      input logic [16:0] se, input logic wr, input logic [1:0] ad,
                      input logic [31:0] wd);
    @(negedge clk);
    crit_ext = ce; main_ext = me; per_ext = pe; sec_evt = se;
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    #1;
    model_eval();
    chk("R2 crit field", {21'd0, stat_word[10:8], 8'd0}, {21'd0, e_stat[10:8], 8'd0});
    chk("R3 main field", {10'd0, stat_word[21:16], 16'd0}, {10'd0, e_stat[21:16], 16'd0});
    chk("R4 R6 peripheral field", {2'd0, stat_word[29:24], 24'd0}, {2'd0, e_stat[29:24], 24'd0});
    chk("R9 unused status bits", stat_word & 32'hC0C0F8FF, 32'd0);
    chk("R7 src_id", {26'd0, src_id}, {26'd0, e_id});
    chk("R8 irq_out", {31'd0, irq_out}, {31'd0, e_stat[10] | e_stat[21] | e_stat[29]});
    chk(ad == 2'd3 ? "R5 pending readback" : "R1 R9 mask readback", reg_rdata, e_rd);
    @(posedge clk);
    if (wr) begin
      case (ad)
        2'd0: m_main = wd[16:0];
        2'd1: m_per = wd & 32'hFFFFFE00;
        2'd2: m_smask = wd[16:0];
        default: ;
      endcase
    end
    m_spend = (m_spend & ~((wr && ad == 2'd3) ? wd[16:0] : 17'd0)) | se;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_main = '1; m_per = 32'hFFFFFE00; m_smask = '1; m_spend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset readback with requests asserted
    for (int a = 0; a < 4; a++) step(3'b000, '1, '1, 17'd0, 1'b0, 2'(a), 32'd0);
    // R2 critical source 3 beats nothing else
    step(3'b100, 16'd0, 22'd0, 17'd0, 1'b0, 2'd0, 32'd0);
    step(3'b111, 16'd0, 22'd0, 17'd0, 1'b0, 2'd0, 32'd0);
    // unmask all
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b1, 2'd0, 32'd0);
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b1, 2'd1, 32'd0);
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b1, 2'd2, 32'd0);
    // R5 set bits 5,7 with a zero write to pending
    step(3'b000, 16'd0, 22'd0, 17'h000A0, 1'b1, 2'd3, 32'd0);
    // R6 cascade via main escape; R5 clear bit 5 while setting bit 1
    step(3'b000, 16'd0, 22'd0, 17'h00002, 1'b1, 2'd3, 32'h22);
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b0, 2'd3, 32'd0);
    // R6 mask bit 1 of secondary
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b1, 2'd2, 32'h2);
    step(3'b000, 16'd0, 22'd0, 17'd0, 1'b0, 2'd3, 32'd0);
    // R2 R4 urgent peripheral 5 via critical escape, plus main source 6
    step(3'b000, 16'h0020, 22'h000010, 17'd0, 1'b0, 2'd1, 32'd0);
    // R3 main mask on source 0 while main 0 requested
    step(3'b000, 16'h0001, 22'd0, 17'd0, 1'b1, 2'd0, 32'h10000);
    step(3'b000, 16'h0003, 22'd0, 17'd0, 1'b0, 2'd0, 32'd0);
    // R4 peripheral mask on source 22
    step(3'b000, 16'd0, 22'h200000, 17'd0, 1'b1, 2'd1, 32'h200);
    step(3'b000, 16'd0, 22'h200001, 17'd0, 1'b0, 2'd1, 32'd0);
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] ad;
      logic [31:0] wd;
      ad = 2'($urandom_range(0, 3));
      wd = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : ($urandom & $urandom & $urandom);
      step(3'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
           22'($urandom & $urandom & $urandom & $urandom),
           17'($urandom & $urandom & $urandom & $urandom),
           $urandom_range(0, 3) == 0, ad, wd);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule